// File: doc/BRIEF.md
# Coefficient-wise Modular Polynomial ALU

This block applies one operation to every coefficient of a polynomial of n entries, where n is a power of two from 64 to 2048 given as log2(n). Each coefficient is 24 bits. Polynomials live in two single-port coefficient memories of 4096 words each, the lower and the upper half of an 8192-entry store. Polynomial number p starts at flat address p << log2(n). Flat address bit 12 selects the memory (0 = lower, 1 = upper), and bits 11:0 are the word inside it. The source and the destination must sit in opposite memories. This lets the source memory be read while the destination memory is read or written in the same cycle.

A single opcode chooses the operation. Arithmetic is modulo a prime q. There is a bit-reversed copy. Bitwise and shift operations combine each source coefficient with a 24-bit scalar. The opcode, q, the scalar, log2(n) and both polynomial numbers are captured on the cycle start is accepted. Start is accepted only while the block is idle. The block raises busy while it works and pulses done for one cycle when it has finished. A request it cannot carry out ends at once with done and err together.

Top module: `coef_alu`

## Requirements
- R1: Opcode 0 writes (src[i] + dst[i]) mod q into dst[i] for all i < n, given inputs in [0, q).
- R2: Opcode 1 writes (src[i] - dst[i]) mod q into dst[i]; the source coefficient is the minuend, and a negative difference wraps to [0, q).
- R3: Opcode 2 writes (src[i] * dst[i]) mod q into dst[i], correct for every q up to 8404993.
- R4: Opcode 3 writes src[rev(i)] into dst[i], where rev reverses the low log2(n) bits of i.
- R5: Opcodes 4, 5 and 6 write (src[i] + s) mod q, (src[i] - s) mod q and (src[i] * s) mod q, where s is the scalar and s < q.
- R6: Opcodes 7, 8 and 9 write src[i] AND s, src[i] OR s and src[i] XOR s.
- R7: Opcode 10 writes src[i] >> s and opcode 11 writes the low 24 bits of src[i] << s. Both are logical shifts, and a shift amount of 24 or more gives 0.
- R8: A start whose source and destination lie in the same memory writes nothing. It raises done and err together in the first cycle after acceptance, with busy low.
- R9: A start with an opcode of 12 to 15 is rejected in the same way as R8: no writes, done and err in the first cycle.
- R10: For opcodes 0 to 2 done is high in cycle 2n+3 after the accepting edge; for the other opcodes it is high in cycle n+4. Done lasts one cycle, busy is high from cycle 1 until done, and err is low. The source memory is never written.
- R11: During and right after reset, busy, done, err and both write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request an operation (taken while idle) |
| opcode | input | 4 | Operation code, 0 to 11 valid |
| logN | input | 4 | log2 of polynomial length, 6 to 11 |
| srcPoly | input | 7 | Source polynomial number |
| dstPoly | input | 7 | Destination polynomial number |
| scalar | input | 24 | Scalar operand for opcodes 4 to 11 |
| modQ | input | 24 | Prime modulus q |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Request rejected (valid with done) |
| bank0Addr | output | 12 | Lower memory word address |
| bank0We | output | 1 | Lower memory write enable |
| bank0Wdata | output | 24 | Lower memory write data |
| bank0Rdata | input | 24 | Lower memory read data (one cycle after address) |
| bank1Addr | output | 12 | Upper memory word address |
| bank1We | output | 1 | Upper memory write enable |
| bank1Wdata | output | 24 | Upper memory write data |
| bank1Rdata | input | 24 | Upper memory read data (one cycle after address) |

## Verification
Each coefficient read is issued in cycle t and its result is written in cycle t+3. The last write of a single-operand run therefore falls in cycle n+3 and done in cycle n+4. A two-operand run issues reads only on alternate cycles, so its done falls in cycle 2n+3. A rejected request shows done and err in cycle 1. The bench counts cycles from the accepting edge, sampling on the falling edge, and checks that done rises exactly in the cycle due. Only after done does it compare the whole destination and source regions with values computed from the requirements.

// File: rtl/coef_alu_pkg.sv
package coef_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_MUL    = 4'd2,
    OP_BITREV = 4'd3,
    OP_CADD   = 4'd4,
    OP_CSUB   = 4'd5,
    OP_CMUL   = 4'd6,
    OP_CAND   = 4'd7,
    OP_COR    = 4'd8,
    OP_CXOR   = 4'd9,
    OP_CSHR   = 4'd10,
    OP_CSHL   = 4'd11
  } aluOp_t;

  typedef struct packed {
    logic load;     // capture configuration at start
    logic capture;  // memory read data valid: latch operands
    logic compute;  // operands valid: latch result
  } dpStrobe_t;

  function automatic logic isBinaryOp(input logic [3:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
  endfunction

  function automatic logic isModOp(input logic [3:0] op);
    return (op <= OP_MUL) || (op == OP_CADD) || (op == OP_CSUB) || (op == OP_CMUL);
  endfunction

endpackage

// File: rtl/coef_alu_ctrl.sv
module coef_alu_ctrl
  import coef_alu_pkg::*;
#(
  parameter int LOGN_MAX = 11,
  parameter int POLY_W   = 7,
  parameter int BANK_AW  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [3:0]         opIn,
  input  logic [3:0]         logNIn,
  input  logic [POLY_W-1:0]  srcPolyIn,
  input  logic [POLY_W-1:0]  dstPolyIn,
  output logic               busy,
  output logic               done,
  output logic               err,
  output dpStrobe_t          strb,
  output logic               srcBank,
  output logic [BANK_AW-1:0] srcBase,
  output logic [BANK_AW-1:0] dstBase,
  output logic [LOGN_MAX-1:0] srcIdx,
  output logic [LOGN_MAX-1:0] rdIdx,
  output logic               wrEn,
  output logic [LOGN_MAX-1:0] wrIdx
);
  localparam int IDX_W  = LOGN_MAX;
  localparam int ADDR_W = BANK_AW + 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_t;

  state_t            state;
  logic [IDX_W-1:0]  idx, i1, i2, i3, lastIdx, revFull;
  logic              phase, v1, v2, v3, doneR, errR;
  logic              binL, revL;
  logic [3:0]        logNL;
  logic [ADDR_W-1:0] srcFull, dstFull, srcFullL, dstFullL;
  logic              reject, accept, issue;

  always_comb begin
    srcFull = ADDR_W'(srcPolyIn) << logNIn;
    dstFull = ADDR_W'(dstPolyIn) << logNIn;
    reject  = (srcFull[ADDR_W-1] == dstFull[ADDR_W-1]) || (opIn > OP_CSHL);
    accept  = (state == S_IDLE) && start && !reject;
    issue   = (state == S_RUN) && (!binL || !phase);
    lastIdx = IDX_W'((32'd1 << logNL) - 32'd1);
    revFull = '0;
    for (int b = 0; b < IDX_W; b++) revFull[b] = idx[IDX_W-1-b];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      idx <= '0; i1 <= '0; i2 <= '0; i3 <= '0;
      phase <= 1'b0; v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      doneR <= 1'b0; errR <= 1'b0;
      binL <= 1'b0; revL <= 1'b0; logNL <= 4'd6;
      srcFullL <= '0; dstFullL <= '0;
    end else begin
      doneR <= 1'b0;
      errR  <= 1'b0;
      v1 <= issue; i1 <= idx;
      v2 <= v1;    i2 <= i1;
      v3 <= v2;    i3 <= i2;
      case (state)
        S_IDLE: begin
          if (start && reject) begin
            doneR <= 1'b1;
            errR  <= 1'b1;
          end else if (accept) begin
            state    <= S_RUN;
            idx      <= '0;
            phase    <= 1'b0;
            binL     <= isBinaryOp(opIn);
            revL     <= (opIn == OP_BITREV);
            logNL    <= logNIn;
            srcFullL <= srcFull;
            dstFullL <= dstFull;
          end
        end
        S_RUN: begin
          phase <= ~phase;
          if (issue) begin
            idx <= idx + 1'b1;
            if (idx == lastIdx) state <= S_DRAIN;
          end
        end
        default: begin
          if (v3 && !v2 && !v1) begin
            state <= S_IDLE;
            doneR <= 1'b1;
          end
        end
      endcase
    end
  end

  assign busy    = (state != S_IDLE);
  assign done    = doneR;
  assign err     = errR;
  assign strb    = '{load: accept, capture: v1, compute: v2};
  assign srcBank = srcFullL[ADDR_W-1];
  assign srcBase = srcFullL[BANK_AW-1:0];
  assign dstBase = dstFullL[BANK_AW-1:0];
  assign srcIdx  = revL ? (revFull >> (IDX_W - int'(logNL))) : idx;
  assign rdIdx   = idx;
  assign wrEn    = v3;
  assign wrIdx   = i3;
endmodule

// File: rtl/coef_alu_dp.sv
module coef_alu_dp
  import coef_alu_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [3:0]        opIn,
  input  logic [DATA_W-1:0] qIn,
  input  logic [DATA_W-1:0] scalarIn,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] dstData,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        opLatched,
  output logic [DATA_W-1:0] qLatched
);
  localparam logic [DATA_W-1:0] SHIFT_LIM = DATA_W'(DATA_W);

  logic [3:0]          opL;
  logic [DATA_W-1:0]   qL, sL, opA, opB, resR, fnOut;
  logic [DATA_W:0]     sum;
  logic [2*DATA_W-1:0] prod;
  logic [DATA_W-1:0]   addR, subR, mulR;

  always_comb begin
    sum  = {1'b0, opA} + {1'b0, opB};
    addR = (sum >= {1'b0, qL}) ? DATA_W'(sum - {1'b0, qL}) : sum[DATA_W-1:0];
    subR = (opA >= opB) ? (opA - opB) : (opA - opB + qL);
    prod = {{DATA_W{1'b0}}, opA} * {{DATA_W{1'b0}}, opB};
    mulR = DATA_W'(prod % {{DATA_W{1'b0}}, qL});
    case (opL)
      OP_ADD, OP_CADD: fnOut = addR;
      OP_SUB, OP_CSUB: fnOut = subR;
      OP_MUL, OP_CMUL: fnOut = mulR;
      OP_CAND:         fnOut = opA & opB;
      OP_COR:          fnOut = opA | opB;
      OP_CXOR:         fnOut = opA ^ opB;
      OP_CSHR:         fnOut = (opB >= SHIFT_LIM) ? '0 : (opA >> opB);
      OP_CSHL:         fnOut = (opB >= SHIFT_LIM) ? '0 : (opA << opB);
      default:         fnOut = opA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opL <= '0; qL <= '0; sL <= '0;
      opA <= '0; opB <= '0; resR <= '0;
    end else begin
      if (strb.load) begin
        opL <= opIn;
        qL  <= qIn;
        sL  <= scalarIn;
      end
      if (strb.capture) begin
        opA <= srcData;
        opB <= isBinaryOp(opL) ? dstData : sL;
      end
      if (strb.compute) resR <= fnOut;
    end
  end

  assign result    = resR;
  assign opLatched = opL;
  assign qLatched  = qL;
endmodule

// File: rtl/coef_alu.sv
module coef_alu #(
  parameter int DATA_W   = 24,
  parameter int LOGN_MAX = 11,
  parameter int POLY_W   = 7,
  parameter int BANK_AW  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [3:0]         opcode,
  input  logic [3:0]         logN,
  input  logic [POLY_W-1:0]  srcPoly,
  input  logic [POLY_W-1:0]  dstPoly,
  input  logic [DATA_W-1:0]  scalar,
  input  logic [DATA_W-1:0]  modQ,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [BANK_AW-1:0] bank0Addr,
  output logic               bank0We,
  output logic [DATA_W-1:0]  bank0Wdata,
  input  logic [DATA_W-1:0]  bank0Rdata,
  output logic [BANK_AW-1:0] bank1Addr,
  output logic               bank1We,
  output logic [DATA_W-1:0]  bank1Wdata,
  input  logic [DATA_W-1:0]  bank1Rdata
);
  import coef_alu_pkg::*;
  localparam int NBANK = 2;

  dpStrobe_t           strb;
  logic                srcBank, wrEn;
  logic [BANK_AW-1:0]  srcBase, dstBase, srcAddr, dstAddr;
  logic [LOGN_MAX-1:0] srcIdx, rdIdx, wrIdx;
  logic [DATA_W-1:0]   srcData, dstData, result, qLatched;
  logic [3:0]          opLatched;
  logic [BANK_AW-1:0]  bAddr  [NBANK];
  logic                bWe    [NBANK];
  logic [DATA_W-1:0]   bWdata [NBANK];
  logic [DATA_W-1:0]   bRdata [NBANK];

  coef_alu_ctrl #(.LOGN_MAX(LOGN_MAX), .POLY_W(POLY_W), .BANK_AW(BANK_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opIn(opcode), .logNIn(logN),
    .srcPolyIn(srcPoly), .dstPolyIn(dstPoly), .busy(busy), .done(done), .err(err),
    .strb(strb), .srcBank(srcBank), .srcBase(srcBase), .dstBase(dstBase),
    .srcIdx(srcIdx), .rdIdx(rdIdx), .wrEn(wrEn), .wrIdx(wrIdx)
  );

  coef_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opIn(opcode), .qIn(modQ), .scalarIn(scalar),
    .srcData(srcData), .dstData(dstData), .result(result),
    .opLatched(opLatched), .qLatched(qLatched)
  );

  assign srcAddr   = srcBase + BANK_AW'(srcIdx);
  assign dstAddr   = dstBase + BANK_AW'(wrEn ? wrIdx : rdIdx);
  assign bRdata[0] = bank0Rdata;
  assign bRdata[1] = bank1Rdata;
  assign srcData   = bRdata[srcBank];
  assign dstData   = bRdata[~srcBank];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic BSEL = (b != 0);
    assign bAddr[b]  = (srcBank == BSEL) ? srcAddr : dstAddr;
    assign bWe[b]    = (srcBank != BSEL) && wrEn;
    assign bWdata[b] = result;
  end

  assign bank0Addr  = bAddr[0];
  assign bank0We    = bWe[0];
  assign bank0Wdata = bWdata[0];
  assign bank1Addr  = bAddr[1];
  assign bank1We    = bWe[1];
  assign bank1Wdata = bWdata[1];
endmodule

// File: rtl/coef_alu_chk.sv
module coef_alu_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              bank0We,
  input logic              bank1We,
  input logic [DATA_W-1:0] bank0Wdata,
  input logic [DATA_W-1:0] bank1Wdata,
  input logic [3:0]        opLatched,
  input logic [DATA_W-1:0] qLatched
);
  import coef_alu_pkg::*;

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R10: done is seen with busy already low
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);
  // R8: err is only reported together with done
  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rstN) err |-> done);
  // R10: only the destination memory is ever written
  p_one_bank_r10: assert property (@(posedge clk) disable iff (!rstN) !(bank0We && bank1Wdata == bank1Wdata && bank1We));
  // R11: writes happen only while an operation is running
  p_write_busy_r11: assert property (@(posedge clk) disable iff (!rstN) (bank0We || bank1We) |-> busy);
  // R1: modular results stay inside [0, q)
  p_mod_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    ((bank0We || bank1We) && isModOp(opLatched)) |-> ((bank0We ? bank0Wdata : bank1Wdata) < qLatched));
endmodule

bind coef_alu coef_alu_chk #(.DATA_W(DATA_W)) u_coef_alu_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .err(err),
  .bank0We(bank0We), .bank1We(bank1We), .bank0Wdata(bank0Wdata), .bank1Wdata(bank1Wdata),
  .opLatched(opLatched), .qLatched(qLatched)
);

// File: tb/coef_alu_bench.sv
`timescale 1ns/1ps
module coef_alu_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [3:0] opcode = '0, logN = 4'd6;
  logic [6:0] srcPoly = '0, dstPoly = '0;
  logic [23:0] scalar = '0, modQ = 24'd3329;
  logic busy, done, err;
  logic [11:0] bank0Addr, bank1Addr;
  logic bank0We, bank1We;
  logic [23:0] bank0Wdata, bank1Wdata, bank0Rdata, bank1Rdata;

  logic [23:0] mem0 [4096];
  logic [23:0] mem1 [4096];
  logic ldEn = 1'b0, ldBank = 1'b0;
  logic [11:0] ldA = '0;
  logic [23:0] ldD = '0;

  int checks = 0, failures = 0;
  int unsigned srcA [2048];
  int unsigned dstA [2048];
  int unsigned expA [2048];

  always #2 clk = ~clk;

  coef_alu u_coef_alu (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .logN(logN),
    .srcPoly(srcPoly), .dstPoly(dstPoly), .scalar(scalar), .modQ(modQ),
    .busy(busy), .done(done), .err(err),
    .bank0Addr(bank0Addr), .bank0We(bank0We), .bank0Wdata(bank0Wdata), .bank0Rdata(bank0Rdata),
    .bank1Addr(bank1Addr), .bank1We(bank1We), .bank1Wdata(bank1Wdata), .bank1Rdata(bank1Rdata)
  );

  always_ff @(posedge clk) begin
    if (ldEn && !ldBank) mem0[ldA] <= ldD;
    else if (bank0We) mem0[bank0Addr] <= bank0Wdata;
    if (ldEn && ldBank) mem1[ldA] <= ldD;
    else if (bank1We) mem1[bank1Addr] <= bank1Wdata;
    bank0Rdata <= mem0[bank0Addr];
    bank1Rdata <= mem1[bank1Addr];
  end

  // op(4) logN(4) src(7) dst(7) scalar(24) q(24)
  localparam logic [69:0] VECS [16] = '{
    {4'd0,  4'd6,  7'd3,  7'd70, 24'd0,        24'd3329},
    {4'd1,  4'd6,  7'd65, 7'd1,  24'd0,        24'd7681},
    {4'd2,  4'd6,  7'd3,  7'd70, 24'd0,        24'd12289},
    {4'd2,  4'd6,  7'd66, 7'd2,  24'd0,        24'd8380417},
    {4'd3,  4'd7,  7'd1,  7'd40, 24'd0,        24'd3329},
    {4'd4,  4'd6,  7'd4,  7'd71, 24'd3000,     24'd3329},
    {4'd5,  4'd6,  7'd4,  7'd71, 24'd5000,     24'd7681},
    {4'd6,  4'd6,  7'd4,  7'd71, 24'd4205000,  24'd4205569},
    {4'd7,  4'd6,  7'd4,  7'd71, 24'hF0F0F0,   24'd8404993},
    {4'd8,  4'd6,  7'd4,  7'd71, 24'h00AA55,   24'd8404993},
    {4'd9,  4'd6,  7'd4,  7'd71, 24'h5A5A5A,   24'd8404993},
    {4'd10, 4'd6,  7'd4,  7'd71, 24'd3,        24'd8404993},
    {4'd10, 4'd6,  7'd4,  7'd71, 24'd24,       24'd8404993},
    {4'd11, 4'd6,  7'd4,  7'd71, 24'd5,        24'd8404993},
    {4'd11, 4'd6,  7'd4,  7'd71, 24'd30,       24'd8404993},
    {4'd3,  4'd11, 7'd0,  7'd2,  24'd0,        24'd3329}
  };

  function automatic string tagOf(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5, 6: return "R5";
      7, 8, 9: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic int unsigned expOf(input int op, input longint unsigned a,
                                        input longint unsigned b, input longint unsigned s,
                                        input longint unsigned q);
    case (op)
      0: return int'((a + b) % q);
      1: return int'((a + q - b) % q);
      2: return int'((a * b) % q);
      4: return int'((a + s) % q);
      5: return int'((a + q - s) % q);
      6: return int'((a * s) % q);
      7: return int'(a & s);
      8: return int'(a | s);
      9: return int'(a ^ s);
      10: return (s >= 24) ? 0 : int'(a >> s);
      11: return (s >= 24) ? 0 : int'((a << s) & 64'hFFFFFF);
      default: return int'(a);
    endcase
  endfunction

  function automatic int revBits(input int i, input int bits);
    int r = 0;
    for (int k = 0; k < bits; k++) if (i[k]) r = r | (1 << (bits - 1 - k));
    return r;
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic loadWord(input logic bank, input int addr, input int unsigned d);
    @(negedge clk);
    ldEn = 1'b1; ldBank = bank; ldA = 12'(addr); ldD = 24'(d);
  endtask

  function automatic logic [23:0] memRd(input logic bank, input int addr);
    return bank ? mem1[addr] : mem0[addr];
  endfunction

  // preload source and destination regions; returns via arrays
  task automatic prepare(input int ln, input int sp, input int dp, input int q);
    int n = 1 << ln;
    int sf = sp << ln;
    int df = dp << ln;
    for (int i = 0; i < n; i++) begin
      srcA[i] = (i == 0) ? q - 1 : (i * 7919 + 13) % q;
      dstA[i] = (i < 2) ? q - 1 : (i * 104729 + 5) % q;
      loadWord(sf[12], (sf & 4095) + i, srcA[i]);
      loadWord(df[12], (df & 4095) + i, dstA[i]);
    end
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  // issue start, return cycle in which done is seen (cycle 1 = first after accept)
  task automatic launch(input int op, input int ln, input int sp, input int dp,
                        input int s, input int q, output int cyc);
    @(negedge clk);
    opcode = 4'(op); logN = 4'(ln); srcPoly = 7'(sp); dstPoly = 7'(dp);
    scalar = 24'(s); modQ = 24'(q); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 10000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic runVec(input int op, input int ln, input int sp, input int dp,
                        input int s, input int q);
    int n = 1 << ln;
    int sf = sp << ln;
    int df = dp << ln;
    int cyc, bad;
    prepare(ln, sp, dp, q);
    for (int i = 0; i < n; i++)
      expA[i] = expOf(op, (op == 3) ? srcA[revBits(i, ln)] : srcA[i], dstA[i], s, q);
    launch(op, ln, sp, dp, s, q, cyc);
    check("R10", $sformatf("done cycle op=%0d", op), cyc, (op <= 2) ? 2 * n + 3 : n + 4);
    check("R10", "err low on good op", err, 0);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      if (memRd(df[12], (df & 4095) + i) != 24'(expA[i])) bad++;
      if (memRd(sf[12], (sf & 4095) + i) != 24'(srcA[i])) bad++;
    end
    check(tagOf(op), $sformatf("mismatched words op=%0d s=%0d q=%0d", op, s, q), bad, 0);
    @(negedge clk);
    check("R10", "done single pulse", done, 0);
  endtask

  task automatic runReject(input string tag, input int op, input int sp, input int dp);
    int cyc, bad;
    int df = dp << 6;
    prepare(6, sp, dp, 3329);
    launch(op, 6, sp, dp, 0, 3329, cyc);
    check(tag, "reject done cycle", cyc, 1);
    check(tag, "reject err", err, 1);
    check(tag, "reject busy", busy, 0);
    repeat (4) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 64; i++)
      if (memRd(df[12], (df & 4095) + i) != 24'(dstA[i])) bad++;
    check(tag, "destination untouched", bad, 0);
  endtask

  initial begin
    #(4 * 190000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs quiet during reset
    check("R11", "busy in reset", busy, 0);
    check("R11", "write enables in reset", bank0We | bank1We, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "busy after reset", busy, 0);
    check("R11", "done after reset", done, 0);
    check("R11", "err after reset", err, 0);

    for (int k = 0; k < 16; k++) begin
      logic [69:0] v = VECS[k];
      runVec(int'(v[69:66]), int'(v[65:62]), int'(v[61:55]), int'(v[54:48]),
             int'(v[47:24]), int'(v[23:0]));
    end

    runReject("R8", 0, 3, 5);     // both in lower memory
    runReject("R8", 6, 70, 100);  // both in upper memory
    runReject("R9", 13, 3, 70);   // unsupported opcode
    runReject("R9", 15, 3, 70);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule